// File: doc/BRIEF.md
# Per-Router Longest Prefix Route Lookup

This block resolves the forwarding decision for IPv4 packets that an earlier stage has already assigned to one of four hardware virtual routers. Each request carries the router number, a flag saying whether the packet is IPv4, and the destination address. The block answers with one of three outcomes. A hit returns a next-hop pointer into a separate next-hop table. A punt sends the packet to the CPU because no route matched. A bypass sends the packet to the CPU without any table search.

All four routing tables share one ternary-style entry store. Each entry carries a router tag that must equal the request's router number exactly. The address part of the entry is a prefix compared under a mask built from the prefix length. Software fills the store through a single write port and keeps entries sorted from longest to shortest prefix, so the lowest-indexed match is the longest prefix. Software can also mark any router as not offloaded. Every request for that router then goes straight to the CPU path. Lookups are fully pipelined: one request can be accepted every cycle, and each result arrives two cycles later.

Top module: `rt_lpm_lookup`

## Requirements
- R1: While reset is asserted `rsp_valid` is 0. After reset every entry is invalid, so any IPv4 lookup on a router that is not bypassed returns a punt.
- R2: A request presented with `req_valid` high in the cycle before clock edge k gives exactly one response, with `rsp_valid` high in the cycle after edge k+1. A new request may be presented every cycle.
- R3: An entry matches only when three things hold: it is valid, its router tag equals `req_vr`, and the top L bits of `req_dst` equal the top L bits of its stored prefix, where L is the entry's length.
- R4: When several entries match, the entry with the lowest index wins. A hit reports `rsp_kind` = 0 and `rsp_nh_idx` equal to that entry's index.
- R5: An entry of length 0 matches every destination for its own router and acts as that router's default route.
- R6: A length of 32 requires every address bit to be equal. Any length above 32 is treated as 32.
- R7: An IPv4 request on a router that is not bypassed and matches no entry returns `rsp_kind` = 1 (punt) with `rsp_nh_idx` = 0.
- R8: A request with `req_is_ip` = 0, or whose router has its bit set in `bypass_mask` (bit n for router n), returns `rsp_kind` = 2 (bypass) with `rsp_nh_idx` = 0, whatever the store holds. The value 3 is never reported.
- R9: An entry tagged with one router never matches a request for another router, even when the addresses match.
- R10: A write with `wr_valid` = 0 removes the entry at `wr_idx`. A write is seen by every request presented after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_valid | input | 1 | Valid bit written to the entry |
| wr_vr | input | 2 | Router tag written to the entry |
| wr_prefix | input | 32 | Address prefix written to the entry |
| wr_len | input | 6 | Prefix length written to the entry (values above 32 act as 32) |
| bypass_mask | input | 4 | One bit per router; a set bit sends that router's traffic to the CPU |
| req_valid | input | 1 | Lookup request strobe |
| req_vr | input | 2 | Router number of the packet |
| req_is_ip | input | 1 | 1 for IPv4 packets, 0 for other protocols |
| req_dst | input | 32 | Destination address |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 hit, 1 punt, 2 bypass |
| rsp_nh_idx | output | 6 | Next-hop pointer on a hit, otherwise 0 |

## Verification
The bench places a shorter prefix below a longer one that also matches, which shows whether the design takes the lowest index or the longest length. A design that ignores the router tag would return another router's next hop, so identical prefixes are loaded under different router tags. The length-0, length-32 and above-32 cases catch a mask generator that is off by one or that wraps; such a design would miss a default route or accept a neighbouring host. Random back-to-back traffic, mixed with non-IP and bypassed routers, catches results that are dropped, duplicated or shifted by a cycle in the pipeline, as well as a bypass that still reports a table hit.

// File: rtl/rt_lpm_pkg.sv
package rt_lpm_pkg;
  typedef enum logic [1:0] {
    RK_HIT    = 2'd0,
    RK_PUNT   = 2'd1,
    RK_BYPASS = 2'd2
  } route_kind_e;
endpackage

// File: rtl/rt_lpm_store.sv
module rt_lpm_store #(
  parameter int ENTRIES = 64,
  parameter int VR_W    = 2,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(ADDR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_valid,
  input  logic [VR_W-1:0]    wr_vr,
  input  logic [ADDR_W-1:0]  wr_prefix,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [VR_W-1:0]    key_vr,
  input  logic [ADDR_W-1:0]  key_addr,
  output logic [ENTRIES-1:0] hit_vec
);
  // Mask with the top 'len' bits set; lengths beyond ADDR_W saturate.
  function automatic logic [ADDR_W-1:0] len_to_mask(input logic [LEN_W-1:0] len);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[b] = ((b + int'(len)) >= ADDR_W);
    end
    return m;
  endfunction

  logic [ADDR_W-1:0] wr_mask;

  always_comb begin
    wr_mask = len_to_mask(wr_len);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              ent_vld;
    logic [VR_W-1:0]   ent_vr;
    logic [ADDR_W-1:0] ent_pfx;
    logic [ADDR_W-1:0] ent_mask;
    logic              ent_we;

    always_comb begin
      ent_we = wr_en && (wr_idx == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld <= 1'b0;
      end else if (ent_we) begin
        ent_vld <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_we) begin
        ent_vr   <= wr_vr;
        ent_pfx  <= wr_prefix;
        ent_mask <= wr_mask;
      end
    end

    always_comb begin
      hit_vec[g] = ent_vld && (ent_vr == key_vr) &&
                   (((key_addr ^ ent_pfx) & ent_mask) == '0);
    end
  end
endmodule

// File: rtl/rt_lpm_prio.sv
module rt_lpm_prio #(
  parameter int WIDTH  = 64,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req_vec,
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!found && req_vec[i]) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rt_lpm_lookup.sv
module rt_lpm_lookup #(
  parameter int ENTRIES  = 64,
  parameter int VR_W     = 2,
  parameter int ADDR_W   = 32,
  localparam int NUM_VR  = 1 << VR_W,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LEN_W   = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VR_W-1:0]   wr_vr,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [NUM_VR-1:0] bypass_mask,
  input  logic              req_valid,
  input  logic [VR_W-1:0]   req_vr,
  input  logic              req_is_ip,
  input  logic [ADDR_W-1:0] req_dst,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [IDX_W-1:0]  rsp_nh_idx
);
  import rt_lpm_pkg::*;

  logic [ENTRIES-1:0] hit_vec;
  logic               req_bypass;

  logic               s1_valid;
  logic [ENTRIES-1:0] s1_hits;
  logic               s1_bypass;

  logic               win_found;
  logic [IDX_W-1:0]   win_idx;

  route_kind_e        kind_d;
  logic [IDX_W-1:0]   nh_d;

  rt_lpm_store #(
    .ENTRIES (ENTRIES),
    .VR_W    (VR_W),
    .ADDR_W  (ADDR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_vr     (wr_vr),
    .wr_prefix (wr_prefix),
    .wr_len    (wr_len),
    .key_vr    (req_vr),
    .key_addr  (req_dst),
    .hit_vec   (hit_vec)
  );

  // Stage 1: capture the match vector and the bypass decision.
  always_comb begin
    req_bypass = !req_is_ip || bypass_mask[req_vr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_hits   <= '0;
      s1_bypass <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_hits   <= hit_vec;
        s1_bypass <= req_bypass;
      end
    end
  end

  // Stage 2: pick the lowest-indexed hit and form the result.
  rt_lpm_prio #(
    .WIDTH (ENTRIES)
  ) u_prio (
    .req_vec (s1_hits),
    .found   (win_found),
    .win_idx (win_idx)
  );

  always_comb begin
    if (s1_bypass) begin
      kind_d = RK_BYPASS;
      nh_d   = '0;
    end else if (win_found) begin
      kind_d = RK_HIT;
      nh_d   = win_idx;
    end else begin
      kind_d = RK_PUNT;
      nh_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_kind   <= RK_PUNT;
      rsp_nh_idx <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_kind   <= kind_d;
        rsp_nh_idx <= nh_d;
      end
    end
  end
endmodule

// File: rtl/rt_lpm_checker.sv
module rt_lpm_checker #(
  parameter int VR_W  = 2,
  parameter int IDX_W = 6,
  localparam int NUM_VR = 1 << VR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VR_W-1:0]   req_vr,
  input logic              req_is_ip,
  input logic [NUM_VR-1:0] bypass_mask,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic [IDX_W-1:0]  rsp_nh_idx
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= 2'd0;
    end else if (age != 2'd2) begin
      age <= age + 2'd1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !rsp_valid);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

  a_r8_nonip_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(req_valid && !req_is_ip, 2)) |-> (rsp_kind == 2'd2));

  a_r8_mask_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(req_valid && bypass_mask[req_vr], 2)) |-> (rsp_kind == 2'd2));

  a_r8_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3));

  a_r7_nohit_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != 2'd0) |-> (rsp_nh_idx == '0));
endmodule

bind rt_lpm_lookup rt_lpm_checker #(
  .VR_W  (VR_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_vr      (req_vr),
  .req_is_ip   (req_is_ip),
  .bypass_mask (bypass_mask),
  .rsp_valid   (rsp_valid),
  .rsp_kind    (rsp_kind),
  .rsp_nh_idx  (rsp_nh_idx)
);

// File: tb/rt_lpm_lookup_bench.sv
module rt_lpm_lookup_bench;
  localparam int N_RAND = 400;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic        wr_valid;
  logic [1:0]  wr_vr;
  logic [31:0] wr_prefix;
  logic [5:0]  wr_len;
  logic [3:0]  bypass_mask;
  logic        req_valid;
  logic [1:0]  req_vr;
  logic        req_is_ip;
  logic [31:0] req_dst;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [5:0]  rsp_nh_idx;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Bench view of the store contents.
  bit          m_vld [64];
  logic [1:0]  m_vr  [64];
  logic [31:0] m_pfx [64];
  logic [5:0]  m_len [64];

  logic [1:0]  exp_kind [N_RAND];
  logic [5:0]  exp_idx  [N_RAND];

  rt_lpm_lookup u_rt_lpm_lookup (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_valid, .wr_vr, .wr_prefix, .wr_len,
    .bypass_mask, .req_valid, .req_vr, .req_is_ip, .req_dst,
    .rsp_valid, .rsp_kind, .rsp_nh_idx
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] bmask(input logic [5:0] len);
    if (len >= 6'd32) return 32'hFFFF_FFFF;
    if (len == 6'd0)  return 32'h0;
    return ~(32'hFFFF_FFFF >> len);
  endfunction

  function automatic void model(input logic [1:0] vr, input logic ip, input logic [31:0] dst,
                                output logic [1:0] kind, output logic [5:0] idx);
    kind = 2'd1;
    idx  = 6'd0;
    if (!ip || bypass_mask[vr]) begin
      kind = 2'd2;
      return;
    end
    for (int i = 63; i >= 0; i--) begin
      if (m_vld[i] && m_vr[i] == vr && ((dst ^ m_pfx[i]) & bmask(m_len[i])) == 32'h0) begin
        kind = 2'd0;
        idx  = 6'(i);
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input bit vld, input logic [1:0] vr,
                             input logic [31:0] pfx, input logic [5:0] len);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = vld; wr_vr = vr; wr_prefix = pfx; wr_len = len;
    m_vld[idx] = vld; m_vr[idx] = vr; m_pfx[idx] = pfx; m_len[idx] = len;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Single lookup, with the expected result given explicitly.
  task automatic lookup(input logic [1:0] vr, input logic ip, input logic [31:0] dst,
                        input logic [1:0] ekind, input logic [5:0] eidx, input string req);
    req_valid = 1'b1; req_vr = vr; req_is_ip = ip; req_dst = dst;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b1, {req, " valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_kind == ekind && rsp_nh_idx == eidx, req,
          {24'h0, rsp_kind, rsp_nh_idx}, {24'h0, ekind, eidx});
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, {req, " single response (R2)"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] k;
    logic [5:0] x;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 0; m_vr[i] = '0; m_pfx[i] = '0; m_len[i] = '0;
    end
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_vr = '0;
    wr_prefix = '0; wr_len = '0; bypass_mask = 4'b0000;
    req_valid = 1'b1; req_vr = '0; req_is_ip = 1'b1; req_dst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R7: empty store punts.
    lookup(2'd0, 1'b1, 32'h0A01_0203, 2'd1, 6'd0, "R1 empty store punt");

    // R3 / R4 / R9.
    write_entry(5, 1, 2'd1, 32'h0A01_0000, 6'd16);
    lookup(2'd1, 1'b1, 32'h0A01_0203, 2'd0, 6'd5, "R3 /16 hit");
    lookup(2'd1, 1'b1, 32'h0A02_0001, 2'd1, 6'd0, "R3 prefix mismatch punt (R7)");
    lookup(2'd2, 1'b1, 32'h0A01_0203, 2'd1, 6'd0, "R9 other router isolated");
    write_entry(2, 1, 2'd1, 32'h0A01_0200, 6'd24);
    lookup(2'd1, 1'b1, 32'h0A01_0203, 2'd0, 6'd2, "R4 longer /24 at lower index");
    lookup(2'd1, 1'b1, 32'h0A01_0303, 2'd0, 6'd5, "R4 falls to /16");
    write_entry(3, 1, 2'd1, 32'h0A00_0000, 6'd8);
    lookup(2'd1, 1'b1, 32'h0A01_0909, 2'd0, 6'd3, "R4 lowest index wins over length");
    write_entry(3, 0, 2'd1, 32'h0A00_0000, 6'd8);

    // R5 default route.
    write_entry(9, 1, 2'd1, 32'hDEAD_BEEF, 6'd0);
    lookup(2'd1, 1'b1, 32'h6300_0001, 2'd0, 6'd9, "R5 default route");
    lookup(2'd0, 1'b1, 32'h6300_0001, 2'd1, 6'd0, "R5 default is per router (R9)");

    // R6 host routes and oversize lengths.
    write_entry(1, 1, 2'd3, 32'hC0A8_0007, 6'd32);
    lookup(2'd3, 1'b1, 32'hC0A8_0007, 2'd0, 6'd1, "R6 /32 exact hit");
    lookup(2'd3, 1'b1, 32'hC0A8_0006, 2'd1, 6'd0, "R6 /32 neighbour miss");
    write_entry(0, 1, 2'd3, 32'h0102_0304, 6'd40);
    lookup(2'd3, 1'b1, 32'h0102_0304, 2'd0, 6'd0, "R6 length 40 exact hit");
    lookup(2'd3, 1'b1, 32'h0102_0305, 2'd1, 6'd0, "R6 length 40 acts as 32");

    // R8 bypass.
    lookup(2'd1, 1'b0, 32'h0A01_0203, 2'd2, 6'd0, "R8 non-IP bypass");
    bypass_mask = 4'b0010;
    lookup(2'd1, 1'b1, 32'h0A01_0203, 2'd2, 6'd0, "R8 masked router bypass");
    lookup(2'd3, 1'b1, 32'hC0A8_0007, 2'd0, 6'd1, "R8 unmasked router still hits");
    bypass_mask = 4'b0000;

    // R10 invalidation.
    write_entry(2, 0, 2'd1, 32'h0A01_0200, 6'd24);
    lookup(2'd1, 1'b1, 32'h0A01_0203, 2'd0, 6'd5, "R10 removed entry no longer hits");

    // Random phase: table sorted by descending length, back-to-back requests.
    for (int i = 0; i < 64; i++) begin
      automatic logic [5:0] len = (i == 63) ? 6'd0 : 6'(32 - i / 2);
      write_entry(i, ($urandom % 8) != 0, 2'($urandom), $urandom, len);
    end
    bypass_mask = 4'b0100;
    for (int i = 0; i < N_RAND + 2; i++) begin
      if (i >= 2) begin
        check(rsp_valid == 1'b1, "R2 streaming valid", 32'(rsp_valid), 32'd1);
        check(rsp_kind == exp_kind[i-2] && rsp_nh_idx == exp_idx[i-2], "R3 R4 random lookup",
              {24'h0, rsp_kind, rsp_nh_idx}, {24'h0, exp_kind[i-2], exp_idx[i-2]});
      end
      if (i < N_RAND) begin
        automatic int e = $urandom % 64;
        automatic logic [31:0] d = $urandom;
        automatic logic [1:0] v = 2'($urandom);
        automatic logic ip = ($urandom % 10) != 0;
        if (($urandom % 4) != 0) begin
          d = (m_pfx[e] & bmask(m_len[e])) | (d & ~bmask(m_len[e]));
          v = m_vr[e];
        end
        model(v, ip, d, k, x);
        exp_kind[i] = k;
        exp_idx[i]  = x;
        req_valid = 1'b1; req_vr = v; req_is_ip = ip; req_dst = d;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    check(rsp_valid == 1'b0, "R2 stream drains", 32'(rsp_valid), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule